// File: doc/BRIEF.md
# Grouped Conversion Frame Scheduler

This block sets the frame timing for a set of oversampling converter channels that share one modulator clock. A channel counts modulator ticks for a selectable decimation ratio. At the end of each frame it raises a one-cycle frame-done strobe. An 8-bit preload value per channel can lengthen single frames. Only the first frame after a start, and the frame after a preload write, are lengthened. The added delay therefore shifts every later frame of that channel by a fixed amount.

Channel 0 is the group master. A channel other than 0 whose grouped flag is set does not start by itself. It starts together with the master, or it waits and joins the master at the next master frame boundary. When it joins, it takes its own preload delay again. Writing a preload value twice before the first write has fully taken effect is misuse. It is recorded in a sticky error flag, and the bad timing is not hidden.

Top module: `sched_group`

## Requirements
- R1: After reset, every frame-done strobe, busy flag and misuse flag is low.
- R2: A running channel's frame lasts 2^(BASE_LOG2+sel) modulator ticks. Here sel is the channel's 2-bit ratio field, with bits [2i+1:2i] of `ch_dsel` belonging to channel i. Each frame ends with a frame-done pulse that is exactly one cycle wide. In continuous mode the frames follow each other with no gap.
- R3: The first frame after a start pulse is longer by the channel's preload value, counted in ticks. Later frames have the plain length. With all ticks present, the first strobe appears (ratio + preload) cycles after the cycle in which the start is sampled.
- R4: A preload of zero adds no cycles to the first frame.
- R5: A preload write does not change the frame in progress. The next frame to begin is lengthened by the new value, and the frames after that are not.
- R6: In single mode (`ch_cont` bit low) a channel gives one strobe, then clears its busy flag. It only runs again after a new start pulse.
- R7: A start pulse on channel 0 starts, in the same cycle, every enabled grouped channel that is idle. Each of them lengthens its first frame by its own preload.
- R8: A start pulse on an idle grouped channel while the master runs holds it busy without counting. It begins a frame at the master's next frame boundary, and that frame is lengthened by its own preload.
- R9: A preload write to a channel whose earlier write is still pending, or whose write-stretched frame has not completed, sets that channel's misuse flag. The flag stays set until reset. A write after that frame has completed does not set it.
- R10: Clearing `ch_on` stops the channel at once. Busy goes low on the next cycle, and no further strobe is given.
- R11: The frame counter advances only in cycles where `mod_tick` is high. When ticks are missing, the strobe is delayed by the same number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mod_tick | input | 1 | Modulator clock enable, one tick per high cycle |
| ch_on | input | NCH | Per-channel enable |
| ch_cont | input | NCH | 1 = continuous, 0 = single conversion |
| ch_grouped | input | NCH | Channel follows master (ignored on channel 0) |
| ch_start | input | NCH | Start pulse per channel |
| ch_dsel | input | 2*NCH | Per-channel decimation ratio select |
| pre_we | input | 1 | Preload write strobe |
| pre_sel | input | SELW | Channel index of the preload write |
| pre_data | input | 8 | Preload value in ticks |
| frame_done | output | NCH | One-cycle end-of-frame strobes |
| ch_busy | output | NCH | Channel running or waiting for the master |
| pre_err | output | NCH | Sticky preload misuse flags |

## Verification
The bench builds the block with NCH = 3 and BASE_LOG2 = 2, which gives frames of 4, 8, 16 or 32 ticks. With such short frames, several stretched and unstretched frames fit into a few dozen cycles. The master boundaries that a rejoining grouped channel must hit, and the narrow window between a preload write and its completed frame, can then be reached with exact expected cycle numbers. Three channels are enough to have a master, a continuous grouped follower and a single-mode grouped follower running at the same time.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_SYNC = 2'd1,
    CH_RUN  = 2'd2
  } ch_state_e;

  localparam int PRE_W  = 8;
  localparam int DSEL_W = 2;

  // ticks in an unstretched frame for a given ratio select
  function automatic int unsigned frame_ticks(input int unsigned base_log2,
                                              input logic [DSEL_W-1:0] sel);
    return 32'd1 << (base_log2 + {30'd0, sel});
  endfunction

endpackage

// File: rtl/sched_preload.sv
module sched_preload
  import sched_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [PRE_W-1:0] data_i,
  input  logic             begin_i,
  input  logic             end_i,
  output logic [PRE_W-1:0] pre_o,
  output logic             pend_o,
  output logic             err_o
);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic             pend_q, pend_d;
  logic             arm_q, arm_d;
  logic             err_q, err_d;

  always_comb begin
    pre_d  = we_i ? data_i : pre_q;
    // a write landing on a frame-begin edge targets the frame after it
    pend_d = we_i | (pend_q & ~begin_i);
    if (begin_i)    arm_d = pend_q;
    else if (end_i) arm_d = 1'b0;
    else            arm_d = arm_q;
    err_d  = err_q | (we_i & (pend_q | arm_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      pend_q <= 1'b0;
      arm_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      pend_q <= pend_d;
      arm_q  <= arm_d;
      err_q  <= err_d;
    end
  end

  assign pre_o  = pre_q;
  assign pend_o = pend_q;
  assign err_o  = err_q;

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
  assert_misuse_flagged_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && (pend_o || arm_q)) |=> err_o);
  assert_pend_consumed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (begin_i && !we_i) |=> !pend_o);

endmodule

// File: rtl/sched_frame_timer.sv
module sched_frame_timer
  import sched_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 5,
  parameter bit          IS_MASTER = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              on_i,
  input  logic              cont_i,
  input  logic              grouped_i,
  input  logic              start_i,
  input  logic              m_entry_i,
  input  logic              m_begin_i,
  input  logic [DSEL_W-1:0] dsel_i,
  input  logic [PRE_W-1:0]  pre_i,
  input  logic              pend_i,
  output logic              entry_o,
  output logic              begin_o,
  output logic              end_o,
  output logic              done_o,
  output logic              busy_o
);

  localparam int unsigned MAX_T = (32'd1 << (BASE_LOG2 + 3)) + 32'd255;
  localparam int          CW    = $clog2(MAX_T);

  ch_state_e        st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [CW-1:0]    lim_q, lim_d;
  logic             done_q, done_d;
  logic             slave, entry, end_ev, begin_ev;
  logic [PRE_W-1:0] ext;

  assign slave = IS_MASTER ? 1'b0 : grouped_i;

  always_comb begin
    end_ev = (st_q == CH_RUN) && on_i && tick_i && (cnt_q == lim_q);
    if (slave)
      entry = on_i && (((st_q == CH_IDLE) && (m_entry_i || (start_i && m_begin_i))) ||
                       ((st_q == CH_SYNC) && m_begin_i));
    else
      entry = on_i && (st_q == CH_IDLE) && start_i;
    begin_ev = entry | (end_ev & cont_i);
    ext      = (entry | pend_i) ? pre_i : '0;

    if (!on_i)                                         st_d = CH_IDLE;
    else if (entry)                                    st_d = CH_RUN;
    else if (end_ev && !cont_i)                        st_d = CH_IDLE;
    else if (slave && (st_q == CH_IDLE) && start_i)    st_d = CH_SYNC;
    else                                               st_d = st_q;

    cnt_d = cnt_q;
    if (begin_ev)                          cnt_d = '0;
    else if ((st_q == CH_RUN) && tick_i)   cnt_d = cnt_q + 1'b1;

    lim_d = lim_q;
    if (begin_ev)
      lim_d = CW'(frame_ticks(BASE_LOG2, dsel_i) + {24'd0, ext} - 32'd1);

    done_d = end_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CH_IDLE;
      cnt_q  <= '0;
      lim_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      lim_q  <= lim_d;
      done_q <= done_d;
    end
  end

  assign entry_o = entry;
  assign begin_o = begin_ev;
  assign end_o   = end_ev;
  assign done_o  = done_q;
  assign busy_o  = (st_q != CH_IDLE);

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_RUN) |-> (cnt_q <= lim_q));
  assert_single_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (end_ev && !cont_i) |=> !busy_o);
  assert_off_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !on_i |=> (!busy_o && !done_o));
  assert_tick_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !begin_ev) |=> $stable(cnt_q));

endmodule

// File: rtl/sched_group.sv
module sched_group
  import sched_pkg::*;
#(
  parameter int unsigned NCH       = 4,
  parameter int unsigned BASE_LOG2 = 5,
  localparam int         SELW      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mod_tick,
  input  logic [NCH-1:0]        ch_on,
  input  logic [NCH-1:0]        ch_cont,
  input  logic [NCH-1:0]        ch_grouped,
  input  logic [NCH-1:0]        ch_start,
  input  logic [DSEL_W*NCH-1:0] ch_dsel,
  input  logic                  pre_we,
  input  logic [SELW-1:0]       pre_sel,
  input  logic [PRE_W-1:0]      pre_data,
  output logic [NCH-1:0]        frame_done,
  output logic [NCH-1:0]        ch_busy,
  output logic [NCH-1:0]        pre_err
);

  logic [1:0] rs_q;
  logic       rst_core;
  logic       m_entry, m_begin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core = rs_q[1];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic             we_l, entry_l, begin_l, end_l, pend_l;
    logic [PRE_W-1:0] pre_l;

    assign we_l = pre_we && (pre_sel == SELW'(i));

    sched_preload u_pre (
      .clk     (clk),
      .rst_n   (rst_core),
      .we_i    (we_l),
      .data_i  (pre_data),
      .begin_i (begin_l),
      .end_i   (end_l),
      .pre_o   (pre_l),
      .pend_o  (pend_l),
      .err_o   (pre_err[i])
    );

    if (i == 0) begin : g_master
      assign m_entry = entry_l;
      assign m_begin = begin_l;
      sched_frame_timer #(.BASE_LOG2(BASE_LOG2), .IS_MASTER(1'b1)) u_tmr (
        .clk (clk), .rst_n (rst_core), .tick_i (mod_tick),
        .on_i (ch_on[i]), .cont_i (ch_cont[i]), .grouped_i (ch_grouped[i]),
        .start_i (ch_start[i]), .m_entry_i (1'b0), .m_begin_i (1'b0),
        .dsel_i (ch_dsel[DSEL_W*i +: DSEL_W]), .pre_i (pre_l), .pend_i (pend_l),
        .entry_o (entry_l), .begin_o (begin_l), .end_o (end_l),
        .done_o (frame_done[i]), .busy_o (ch_busy[i])
      );
    end else begin : g_follow
      sched_frame_timer #(.BASE_LOG2(BASE_LOG2), .IS_MASTER(1'b0)) u_tmr (
        .clk (clk), .rst_n (rst_core), .tick_i (mod_tick),
        .on_i (ch_on[i]), .cont_i (ch_cont[i]), .grouped_i (ch_grouped[i]),
        .start_i (ch_start[i]), .m_entry_i (m_entry), .m_begin_i (m_begin),
        .dsel_i (ch_dsel[DSEL_W*i +: DSEL_W]), .pre_i (pre_l), .pend_i (pend_l),
        .entry_o (entry_l), .begin_o (begin_l), .end_o (end_l),
        .done_o (frame_done[i]), .busy_o (ch_busy[i])
      );
      // a grouped follower only leaves idle or waiting at a master frame boundary
      assert_follow_aligned_R8: assert property (@(posedge clk) disable iff (!rst_core)
        (ch_grouped[i] && entry_l) |-> m_begin);
    end
  end

endmodule

// File: tb/test_sched_group.sv
module test_sched_group;
  localparam int NCH  = 3;
  localparam int BASE = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             mod_tick;
  logic [NCH-1:0]   ch_on, ch_cont, ch_grouped, ch_start;
  logic [2*NCH-1:0] ch_dsel;
  logic             pre_we;
  logic [1:0]       pre_sel;
  logic [7:0]       pre_data;
  logic [NCH-1:0]   frame_done, ch_busy, pre_err;

  always #10 clk = ~clk;

  sched_group #(.NCH(NCH), .BASE_LOG2(BASE)) i_sched_group (
    .clk (clk), .rst_n (rst_n), .mod_tick (mod_tick),
    .ch_on (ch_on), .ch_cont (ch_cont), .ch_grouped (ch_grouped),
    .ch_start (ch_start), .ch_dsel (ch_dsel), .pre_we (pre_we),
    .pre_sel (pre_sel), .pre_data (pre_data), .frame_done (frame_done),
    .ch_busy (ch_busy), .pre_err (pre_err)
  );

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  int    eq0[$];
  int    eq1[$];
  int    eq2[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic push_done(input int ch, input int t);
    case (ch)
      0: eq0.push_back(t);
      1: eq1.push_back(t);
      default: eq2.push_back(t);
    endcase
  endtask

  task automatic mon_one(input int ch, input logic d, ref int q[$]);
    bit due;
    due = (q.size() > 0) && (q[0] == cyc);
    if (d || due) begin
      checks++;
      if (due) void'(q.pop_front());
      if (!(d && due)) begin
        errors++;
        $display("FAIL %s ch%0d strobe at cycle %0d: actual %0b expected %0b",
                 tag, ch, cyc, d, due);
      end
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    mon_one(0, frame_done[0], eq0);
    mon_one(1, frame_done[1], eq1);
    mon_one(2, frame_done[2], eq2);
  end

  task automatic do_reset();
    rst_n = 1'b0; mod_tick = 1'b1; ch_on = '0; ch_cont = '0; ch_grouped = '0;
    ch_start = '0; ch_dsel = '0; pre_we = 1'b0; pre_sel = '0; pre_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_start(input int ch, output int c);
    @(negedge clk);
    ch_start[ch] = 1'b1;
    c = cyc;
    @(negedge clk);
    ch_start[ch] = 1'b0;
  endtask

  task automatic wr_pre(input int ch, input int v);
    @(negedge clk);
    pre_we = 1'b1; pre_sel = 2'(ch); pre_data = 8'(v);
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic drain(input string req);
    repeat (5) @(negedge clk);
    chk(req, eq0.size() + eq1.size() + eq2.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c, s, t1, t2, t3, t4;

    // R1: reset state
    do_reset();
    tag = "R1";
    chk("R1 done", frame_done, 0);
    chk("R1 busy", ch_busy, 0);
    chk("R1 err", pre_err, 0);

    // R2/R3/R10: continuous ratio 8, preload 5 on first frame only, then stop
    tag = "R3";
    ch_on[0] = 1'b1; ch_cont[0] = 1'b1; ch_dsel[1:0] = 2'd1;
    wr_pre(0, 5);
    pulse_start(0, c);
    s = c + 1;
    push_done(0, s + 13); push_done(0, s + 21);
    push_done(0, s + 29); push_done(0, s + 37);
    wait_until(s + 40);
    tag = "R10";
    ch_on[0] = 1'b0;
    @(negedge clk);
    chk("R10 busy after disable", ch_busy[0], 0);
    repeat (20) @(negedge clk);
    drain("R10");

    // R4/R6: single mode, zero preload, ratio 4
    do_reset();
    tag = "R4";
    ch_on[1] = 1'b1; ch_dsel[3:2] = 2'd0;
    pulse_start(1, c);
    push_done(1, c + 5);
    wait_until(c + 5);
    tag = "R6";
    chk("R6 busy after single frame", ch_busy[1], 0);
    repeat (15) @(negedge clk);
    chk("R6 stays idle", ch_busy[1], 0);
    pulse_start(1, c);
    push_done(1, c + 5);
    drain("R6");

    // R5/R9: write mid-frame stretches next frame only; misuse flag
    do_reset();
    tag = "R5";
    ch_on[0] = 1'b1; ch_cont[0] = 1'b1; ch_dsel[1:0] = 2'd0;
    pulse_start(0, c);
    s  = c + 1;
    t1 = s + 4; t2 = t1 + 4; t3 = t2 + 7; t4 = t3 + 4;
    push_done(0, t1); push_done(0, t2); push_done(0, t3); push_done(0, t4);
    wait_until(t1);
    wr_pre(0, 3);
    chk("R9 single write no error", pre_err[0], 0);
    wait_until(t3);
    wr_pre(0, 0);
    chk("R9 write after completed frame", pre_err[0], 0);
    tag = "R9";
    wr_pre(0, 0);
    chk("R9 back-to-back write flagged", pre_err[0], 1);
    ch_on[0] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 flag sticky", pre_err[0], 1);
    drain("R5");

    // R7/R8: grouped start and re-synchronisation
    do_reset();
    tag = "R7";
    ch_on = 3'b111; ch_cont = 3'b011; ch_grouped = 3'b110;
    ch_dsel = {2'd1, 2'd0, 2'd1};
    wr_pre(1, 3);
    wr_pre(2, 5);
    pulse_start(0, c);
    s = c + 1;
    for (int k = 1; k <= 5; k++) push_done(0, s + 8 * k);
    for (int k = 0; k <= 8; k++) push_done(1, s + 7 + 4 * k);
    push_done(2, s + 13);
    push_done(2, s + 37);
    chk("R7 group busy together", ch_busy, 3'b111);
    wait_until(s + 20);
    tag = "R8";
    pulse_start(2, c);
    chk("R8 follower waits busy", ch_busy[2], 1);
    wait_until(s + 40);
    ch_on = '0;
    drain("R8");

    // R11: counting paused while ticks are absent
    do_reset();
    tag = "R11";
    ch_on[1] = 1'b1; ch_dsel[3:2] = 2'd0;
    mod_tick = 1'b0;
    pulse_start(1, c);
    s = c + 1;
    push_done(1, s + 14);
    wait_until(s + 10);
    chk("R11 busy while paused", ch_busy[1], 1);
    mod_tick = 1'b1;
    drain("R11");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule